// File: doc/BRIEF.md
# Latched Event Status Register with Interrupt

This block collects hardware events into eight sticky bits and presents them to a host over a small register port. Each event input is synchronised to the clock, and its rising edge sets a latch bit. The latch stays set until the host clears it.

The host works in two steps. First it writes a select byte to the status address. For every 1 in that byte, the current latch value is copied into a held snapshot register and the latch is cleared. For every 0, the snapshot bit keeps its old value and the latch is left alone. The host then reads the status address to get the snapshot.

Because events can arrive at any time relative to host accesses, a set that lands in the same cycle as a clear takes priority. This means no event is lost. The host can write back the read value ANDed with its select byte to clear any bit that was set again.

A per-bit mask register decides which events drive the active-low interrupt line. A separate group of real-time status inputs can be read at their own address. Writes never change them.

Top module: `evt_status_reg`

## Requirements
- R1: After reset, the latches, the snapshot (address 0), the mask (address 1) and the interrupt-pending state are all zero, and `irqN` is 1.
- R2: A 0-to-1 transition on `evtIn[i]` sets latch bit i three clock edges later. A level held high sets the latch only once.
- R3: Writing the status address (address 0) with bit i = 1 loads snapshot bit i from latch bit i and clears latch bit i.
- R4: Writing the status address with bit i = 0 leaves snapshot bit i unchanged and leaves latch bit i unchanged.
- R5: If a rising edge sets latch bit i in the same cycle that a status write selects bit i, the latch stays 1.
- R6: Reading address 2 returns `rtIn` after a two-flop synchroniser. Writes to address 0 or address 2 do not change it.
- R7: Mask bit i = 1 enables event bit i onto the interrupt. An event whose mask bit is 0 never pulls `irqN` low.
- R8: `irqN` goes low when an unmasked latch bit is set.
- R9: After a select write on the causing bit, `irqN` stays low until the next read of address 0. It then returns high if no other unmasked bit is latched or unread; otherwise it stays low.
- R10: The mask register is written and read back at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 status, 1 mask, 2 real-time) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| evtIn | input | 8 | Asynchronous event inputs |
| rtIn | input | 8 | Asynchronous real-time status inputs |
| irqN | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that:
- a synchronised rising edge always leaves its latch bit set, even under a concurrent clear;
- a select write clears only selected bits that are not being set again;
- unselected snapshot bits never move;
- `irqN` is low whenever an unmasked latch bit is set, and high when the mask is zero.

The bench scenarios show the behaviours that span several accesses:
- the three-edge capture latency and the single set from a held level;
- the release of `irqN` only after the read that follows a select write;
- an interrupt held low by a second pending bit;
- the immunity of the real-time bits to writes.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RT   = 2'd2;

  typedef enum logic [1:0] {
    SEL_SNAP = 2'd0,
    SEL_MASK = 2'd1,
    SEL_RT   = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   statWr;
    logic   maskWr;
    logic   statRd;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);
  always_comb begin
    strb.statWr = wrEn && (addr == ADDR_STAT);
    strb.maskWr = wrEn && (addr == ADDR_MASK);
    strb.statRd = rdEn && (addr == ADDR_STAT);
    unique case (addr)
      ADDR_STAT: strb.rdSel = SEL_SNAP;
      ADDR_MASK: strb.rdSel = SEL_MASK;
      ADDR_RT:   strb.rdSel = SEL_RT;
      default:   strb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] evtIn,
  input  logic [WIDTH-1:0] rtIn,
  output logic [WIDTH-1:0] rdData,
  output logic             irqN
);
  localparam int EVT_DEPTH = SYNC_STAGES + 1;

  logic [WIDTH-1:0] evtPipe [EVT_DEPTH];
  logic [WIDTH-1:0] rtPipe  [SYNC_STAGES];
  logic [WIDTH-1:0] rise, latch, snap, mask, unread, sel;

  assign sel = strb.statWr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evtPipe[0] <= '0;
      rtPipe[0]  <= '0;
    end else begin
      evtPipe[0] <= evtIn;
      rtPipe[0]  <= rtIn;
    end
  end

  for (genvar k = 1; k < EVT_DEPTH; k++) begin : g_evtSync
    always_ff @(posedge clk) begin
      if (!rst_n) evtPipe[k] <= '0;
      else        evtPipe[k] <= evtPipe[k-1];
    end
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_rtSync
    always_ff @(posedge clk) begin
      if (!rst_n) rtPipe[k] <= '0;
      else        rtPipe[k] <= rtPipe[k-1];
    end
  end

  assign rise = evtPipe[SYNC_STAGES-1] & ~evtPipe[SYNC_STAGES];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        latch[i]  <= 1'b0;
        snap[i]   <= 1'b0;
        unread[i] <= 1'b0;
      end else begin
        latch[i] <= rise[i] | (latch[i] & ~sel[i]);
        if (sel[i]) snap[i] <= latch[i];
        if (sel[i] && latch[i]) unread[i] <= 1'b1;
        else if (strb.statRd)   unread[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           mask <= '0;
    else if (strb.maskWr) mask <= wrData;
  end

  assign irqN = ~|((latch | unread) & mask);

  always_comb begin
    unique case (strb.rdSel)
      SEL_SNAP: rdData = snap;
      SEL_MASK: rdData = mask;
      SEL_RT:   rdData = rtPipe[SYNC_STAGES-1];
      default:  rdData = '0;
    endcase
  end

  // R2 / R5: a detected edge always leaves its latch set
  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((latch & $past(rise)) == $past(rise)));

  // R3: selected bits with no fresh edge end up cleared
  p_sel_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.statWr |=> ((latch & $past(wrData) & ~$past(rise)) == '0));

  // R4: unselected snapshot bits hold
  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.statWr |=> (((snap ^ $past(snap)) & ~$past(wrData)) == '0));

  // R8: an unmasked latched bit keeps the interrupt low
  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(latch & mask)) |-> !irqN);

  // R7: with everything masked the interrupt stays high
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irqN);
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_status_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  evtIn,
  input  logic [WIDTH-1:0]  rtIn,
  output logic              irqN
);
  ctrlStrobes_t strb;

  evt_status_ctrl u_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  evt_status_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wrData (wrData),
    .evtIn  (evtIn),
    .rtIn   (rtIn),
    .rdData (rdData),
    .irqN   (irqN)
  );
endmodule

// File: tb/evt_status_reg_tb.sv
module evt_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0, evtIn = '0, rtIn = '0;
  logic [7:0] rdData;
  logic       irqN;
  int         nChecks = 0, nFails = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  evt_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtIn(evtIn), .rtIn(rtIn), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] bits);
    @(negedge clk);
    evtIn = evtIn | bits;
    cycles(4);
    evtIn = evtIn & ~bits;
    cycles(3);
  endtask

  task automatic selRead(input string req, input logic [7:0] s,
                         input logic [7:0] cmp, input logic [7:0] exp);
    logic [7:0] d;
    regWrite(2'd0, s);
    regRead(2'd0, d);
    check(req, d & cmp, exp & cmp);
  endtask

  task automatic testReset();
    regRead(2'd0, got); check("R1 snapshot", got, 8'h00);
    regRead(2'd1, got); check("R1 mask", got, 8'h00);
    check("R1 irqN", {7'd0, irqN}, 8'h01);
  endtask

  task automatic testCapture();
    pulseEvt(8'h05);
    selRead("R2/R3 capture", 8'h05, 8'hFF, 8'h05);
    selRead("R3 cleared", 8'h05, 8'h05, 8'h00);
    // held level sets only once
    @(negedge clk); evtIn[7] = 1'b1; cycles(4);
    selRead("R2 level first", 8'h80, 8'h80, 8'h80);
    cycles(4);
    selRead("R2 level no reset", 8'h80, 8'h80, 8'h00);
    evtIn[7] = 1'b0; cycles(3);
  endtask

  task automatic testHold();
    regWrite(2'd0, 8'h00); // snapshot all zero after these selects
    selRead("R4 prep", 8'hFF, 8'hFF, 8'h00);
    pulseEvt(8'h30);
    selRead("R4 partial select", 8'h10, 8'hFF, 8'h10);
    selRead("R4 latch untouched", 8'h20, 8'hFF, 8'h30);
  endtask

  task automatic testSetWins();
    @(negedge clk);
    evtIn[6] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wrData = 8'h40;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    evtIn[6] = 1'b0;
    selRead("R5 set wins", 8'h40, 8'h40, 8'h40);
    cycles(3);
  endtask

  task automatic testRealTime();
    @(negedge clk); rtIn = 8'hA5; cycles(3);
    regRead(2'd2, got); check("R6 rt read", got, 8'hA5);
    regWrite(2'd0, 8'hFF);
    regWrite(2'd2, 8'h00);
    regRead(2'd2, got); check("R6 rt after writes", got, 8'hA5);
  endtask

  task automatic testIrq();
    regWrite(2'd1, 8'h01);
    regRead(2'd1, got); check("R10 mask readback", got, 8'h01);
    pulseEvt(8'h02);
    check("R7 masked event", {7'd0, irqN}, 8'h01);
    pulseEvt(8'h01);
    check("R8 irq low", {7'd0, irqN}, 8'h00);
    regWrite(2'd0, 8'h01);
    check("R9 held until read", {7'd0, irqN}, 8'h00);
    regRead(2'd0, got);
    check("R9 snapshot", got & 8'h01, 8'h01);
    check("R9 released", {7'd0, irqN}, 8'h01);
    regWrite(2'd1, 8'h03);
    check("R8 bit1 unmasked", {7'd0, irqN}, 8'h00);
    pulseEvt(8'h01);
    selRead("R9 other pending", 8'h01, 8'h01, 8'h01);
    check("R9 stays low", {7'd0, irqN}, 8'h00);
    selRead("R9 clear second", 8'h02, 8'h02, 8'h02);
    check("R9 finally high", {7'd0, irqN}, 8'h01);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    testReset();
    testCapture();
    testHold();
    testSetWins();
    testRealTime();
    testIrq();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule